// File: doc/BRIEF.md
# Wavefront Global Alignment Scorer

This block computes the global alignment score of two symbol strings by dynamic programming and returns only the score of the final grid node. No path data is kept, so it serves as a fast screening pass that decides whether a full alignment is worth computing. The score grid has one row per symbol of string A and one column per symbol of string B. Node (i,j) takes the largest of three candidates: node (i-1,j-1) plus the substitution score of the two symbols, node (i-1,j) plus the gap cost, and node (i,j-1) plus the gap cost. Row 0 and column 0 hold multiples of the gap cost.

A linear array of `LANES` cells works on a strip of `LANES` rows at a time. Cell k runs one column behind cell k-1, so every node on one anti-diagonal is computed in the same cycle. The bottom row of each strip goes into a row buffer and becomes the upper boundary of the next strip. Before a run, software-side logic writes the substitution table and both strings through plain write ports while the block is idle. A one-cycle `start` then latches the lengths and the gap cost.

The controller has four states. IDLE waits for `start` (IDLE→PRIME). PRIME loads each cell's left and diagonal boundary values for the strip (PRIME→SWEEP). SWEEP advances the wavefront one step per cycle for `len_b+LANES-1` steps (SWEEP→WRAP on the last step). WRAP either moves to the next strip (WRAP→PRIME) or captures the score and raises `done` (WRAP→IDLE).

Top module: `wavefront_score`

## Requirements
- R1: After reset `busy` and `done` are 0 and `score` is 0.
- R2: The `score` reported with `done` equals H(len_a,len_b) of the recurrence described above. H(i,0)=i·gap and H(0,j)=j·gap. Scores are signed 18-bit values, and every sum saturates to that range.
- R3: When `len_a` exceeds `LANES`, the block processes successive strips of `LANES` rows. The result is correct whether or not `len_a` is a multiple of `LANES`.
- R4: Every length from 1 to the maximum (`MAX_A`, `MAX_B`) is accepted on either string, including both extremes.
- R5: The substitution table is addressed by `{a_sym, b_sym}`, with the string-A symbol in the upper 5 bits, and holds signed 8-bit entries. Sequence writes use `seq_is_b`=0 for string A and 1 for string B. Table and sequence writes made while `busy` is high have no effect.
- R6: A `start` pulse while `busy` is high has no effect on the run in progress or on its result.
- R7: `busy` rises in the cycle after an accepted `start`, and `done` clears at the same edge. `done` rises together with the fall of `busy`. `done` and `score` then hold until the next accepted `start`.
- R8: `gap`, `len_a` and `len_b` are sampled only when `start` is accepted. Changing them during a run does not alter its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tab_we | input | 1 | Substitution table write enable |
| tab_addr | input | 10 | Table address {a_sym, b_sym} |
| tab_data | input | 8 | Signed table entry |
| seq_we | input | 1 | Sequence symbol write enable |
| seq_is_b | input | 1 | 0 selects string A, 1 selects string B |
| seq_addr | input | 4 | Symbol position (0-based) |
| seq_sym | input | 5 | Symbol code |
| len_a | input | 5 | Length of string A (1..MAX_A) |
| len_b | input | 5 | Length of string B (1..MAX_B) |
| gap | input | 8 | Signed gap cost |
| start | input | 1 | Run request, taken only when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Score valid |
| score | output | 18 | Signed score of the last node |

## Verification
The checks assume that any accepted `start` carries lengths between 1 and the configured maxima. The bench draws every length it uses from that range. The embedded checks also assume that the table and both strings are fully written before the first run, so the cells never combine undefined entries. The bench loads all 1024 table entries and every string position before it issues a `start`. The bench deliberately disturbs the write ports, `start`, `gap` and the length ports only while `busy` is high, which is the window in which R5, R6 and R8 say these inputs have no effect.

// File: rtl/wf_pkg.sv
package wf_pkg;
    localparam int SYM_W   = 5;
    localparam int SUB_W   = 8;
    localparam int SCORE_W = 18;

    typedef logic signed [SUB_W-1:0]   sub_t;
    typedef logic signed [SCORE_W-1:0] score_t;

    typedef enum logic [1:0] {S_IDLE, S_PRIME, S_SWEEP, S_WRAP} wf_state_t;

    localparam score_t SCORE_MAX = {1'b0, {(SCORE_W-1){1'b1}}};
    localparam score_t SCORE_MIN = {1'b1, {(SCORE_W-1){1'b0}}};

    function automatic score_t sat_add(score_t a, sub_t b);
        logic signed [SCORE_W:0] s;
        s = {a[SCORE_W-1], a} + {{(SCORE_W+1-SUB_W){b[SUB_W-1]}}, b};
        if (s[SCORE_W] != s[SCORE_W-1])
            return s[SCORE_W] ? SCORE_MIN : SCORE_MAX;
        return s[SCORE_W-1:0];
    endfunction

    function automatic score_t sat_mul(int n, sub_t g);
        int p;
        p = n * int'(g);
        if (p > int'(SCORE_MAX)) return SCORE_MAX;
        if (p < int'(SCORE_MIN)) return SCORE_MIN;
        return SCORE_W'(p);
    endfunction

    function automatic score_t max3(score_t x, score_t y, score_t z);
        score_t m;
        m = (x > y) ? x : y;
        return (m > z) ? m : z;
    endfunction
endpackage

// File: rtl/wf_ctrl.sv
module wf_ctrl
    import wf_pkg::*;
#(
    parameter int LANES = 4,
    parameter int MAX_A = 16,
    parameter int MAX_B = 16,
    localparam int LA_W = $clog2(MAX_A + 1),
    localparam int LB_W = $clog2(MAX_B + 1),
    localparam int T_W  = $clog2(MAX_B + LANES + 1),
    localparam int R_W  = $clog2(MAX_A + LANES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [LA_W-1:0] len_a,
    input  logic [LB_W-1:0] len_b,
    output logic            busy,
    output logic            done,
    output logic            prime,
    output logic            sweep,
    output logic            finish,
    output logic [T_W-1:0]  step,
    output logic [R_W-1:0]  base,
    output logic [LA_W-1:0] len_a_q,
    output logic [LB_W-1:0] len_b_q
);
    wf_state_t state, nxt;
    logic last_step, last_strip;

    assign last_step  = int'(step) == int'(len_b_q) + LANES - 1;
    assign last_strip = int'(base) + LANES >= int'(len_a_q);

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = S_PRIME;
            S_PRIME: nxt = S_SWEEP;
            S_SWEEP: if (last_step) nxt = S_WRAP;
            S_WRAP:  nxt = last_strip ? S_IDLE : S_PRIME;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step    <= '0;
            base    <= '0;
            len_a_q <= '0;
            len_b_q <= '0;
            done    <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    len_a_q <= len_a;
                    len_b_q <= len_b;
                    base    <= '0;
                    done    <= 1'b0;
                end
                S_PRIME: step <= T_W'(1);
                S_SWEEP: step <= step + T_W'(1);
                S_WRAP: begin
                    if (last_strip) done <= 1'b1;
                    else            base <= base + R_W'(LANES);
                end
            endcase
        end
    end

    always_comb begin
        busy   = (state != S_IDLE);
        prime  = (state == S_PRIME);
        sweep  = (state == S_SWEEP);
        finish = (state == S_WRAP) && last_strip;
    end

    assert_len_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start) |-> (len_a >= 1 && int'(len_a) <= MAX_A &&
                                         len_b >= 1 && int'(len_b) <= MAX_B));
    assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start) |=> (busy && !done));
    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !busy && !start) |=> done);
    assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sweep |-> (step >= 1 && int'(step) <= int'(len_b_q) + LANES - 1));
endmodule

// File: rtl/wf_cell.sv
module wf_cell
    import wf_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   init,
    input  score_t init_left,
    input  score_t init_diag,
    input  logic   en,
    input  score_t up,
    input  sub_t   sub,
    input  sub_t   gap,
    output score_t h
);
    score_t diag;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h    <= '0;
            diag <= '0;
        end else if (init) begin
            h    <= init_left;
            diag <= init_diag;
        end else if (en) begin
            h    <= max3(sat_add(diag, sub), sat_add(up, gap), sat_add(h, gap));
            diag <= up;
        end
    end

    assert_init_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(init && en));
    assert_not_below_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> h >= sat_add($past(up), $past(gap)));
endmodule

// File: rtl/wf_rowbuf.sv
module wf_rowbuf
    import wf_pkg::*;
#(
    parameter int MAX_B = 16,
    localparam int AW = $clog2(MAX_B + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  score_t        wdata,
    input  logic [AW-1:0] raddr,
    output score_t        rdata
);
    score_t mem [MAX_B+1];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

    assert_wr_col_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (waddr >= 1 && int'(waddr) <= MAX_B));
endmodule

// File: rtl/wf_subtab.sv
module wf_subtab
    import wf_pkg::*;
#(
    parameter int LANES = 4,
    localparam int AW = 2 * SYM_W
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [AW-1:0]             waddr,
    input  sub_t                      wdata,
    input  logic [LANES-1:0][AW-1:0]  raddr,
    output sub_t                      rdata [LANES]
);
    sub_t mem [2**AW];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_rd
        assign rdata[k] = mem[raddr[k]];
    end
endmodule

// File: rtl/wavefront_score.sv
module wavefront_score
    import wf_pkg::*;
#(
    parameter int LANES = 4,
    parameter int MAX_A = 16,
    parameter int MAX_B = 16,
    localparam int LA_W = $clog2(MAX_A + 1),
    localparam int LB_W = $clog2(MAX_B + 1),
    localparam int SQ_W = $clog2((MAX_A > MAX_B) ? MAX_A : MAX_B),
    localparam int T_W  = $clog2(MAX_B + LANES + 1),
    localparam int R_W  = $clog2(MAX_A + LANES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tab_we,
    input  logic [2*SYM_W-1:0] tab_addr,
    input  logic [SUB_W-1:0]   tab_data,
    input  logic               seq_we,
    input  logic               seq_is_b,
    input  logic [SQ_W-1:0]    seq_addr,
    input  logic [SYM_W-1:0]   seq_sym,
    input  logic [LA_W-1:0]    len_a,
    input  logic [LB_W-1:0]    len_b,
    input  logic [SUB_W-1:0]   gap,
    input  logic               start,
    output logic               busy,
    output logic               done,
    output logic [SCORE_W-1:0] score
);
    localparam int SA_W = $clog2(MAX_A);
    localparam int SB_W = $clog2(MAX_B);

    logic            prime, sweep, finish;
    logic [T_W-1:0]  step;
    logic [R_W-1:0]  base;
    logic [LA_W-1:0] len_a_q;
    logic [LB_W-1:0] len_b_q;
    sub_t            gap_q;
    score_t          score_q;

    logic [SYM_W-1:0] seq_a [MAX_A];
    logic [SYM_W-1:0] seq_b [MAX_B];

    wf_ctrl #(.LANES(LANES), .MAX_A(MAX_A), .MAX_B(MAX_B)) u_ctrl (
        .clk, .rst_n, .start, .len_a, .len_b,
        .busy, .done, .prime, .sweep, .finish,
        .step, .base, .len_a_q, .len_b_q
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q   <= '0;
            score_q <= '0;
        end else begin
            if (!busy && start) gap_q <= sub_t'(gap);
            if (finish)         score_q <= fin_h;
        end
    end

    always_ff @(posedge clk) begin
        if (seq_we && !busy) begin
            if (seq_is_b) seq_b[SB_W'(seq_addr)] <= seq_sym;
            else          seq_a[SA_W'(seq_addr)] <= seq_sym;
        end
    end

    logic [LANES-1:0][2*SYM_W-1:0] rd_addr;
    sub_t   sub_v  [LANES];
    score_t h      [LANES];
    score_t up_v   [LANES];
    logic   lane_en[LANES];
    score_t fin_h;

    wf_subtab #(.LANES(LANES)) u_tab (
        .clk, .we(tab_we && !busy), .waddr(tab_addr), .wdata(sub_t'(tab_data)),
        .raddr(rd_addr), .rdata(sub_v)
    );

    logic [LB_W-1:0] wr_col, rd_col;
    logic            wr_en;
    score_t          row_rd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en  <= 1'b0;
            wr_col <= '0;
        end else begin
            wr_en  <= lane_en[LANES-1];
            wr_col <= LB_W'(int'(step) - (LANES - 1));
        end
    end

    assign rd_col = (int'(step) <= MAX_B) ? LB_W'(step) : '0;

    wf_rowbuf #(.MAX_B(MAX_B)) u_row (
        .clk, .rst_n, .we(wr_en), .waddr(wr_col), .wdata(h[LANES-1]),
        .raddr(rd_col), .rdata(row_rd)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [SYM_W-1:0] a_sym, b_sym;
        int               row_i;

        assign row_i      = int'(base) + k;
        assign lane_en[k] = sweep && (int'(step) > k) && (int'(step) - k <= int'(len_b_q));
        assign a_sym      = (row_i < MAX_A) ? seq_a[SA_W'(row_i)] : '0;
        assign b_sym      = lane_en[k] ? seq_b[SB_W'(int'(step) - k - 1)] : '0;
        assign rd_addr[k] = {a_sym, b_sym};

        if (k == 0) begin : g_head
            assign up_v[k] = (base == '0) ? sat_mul(int'(step), gap_q) : row_rd;
        end else begin : g_body
            assign up_v[k] = h[k-1];
        end

        wf_cell u_cell (
            .clk, .rst_n, .init(prime),
            .init_left(sat_mul(row_i + 1, gap_q)),
            .init_diag(sat_mul(row_i, gap_q)),
            .en(lane_en[k]), .up(up_v[k]), .sub(sub_v[k]), .gap(gap_q),
            .h(h[k])
        );
    end

    always_comb begin
        fin_h = '0;
        for (int k = 0; k < LANES; k++)
            if (int'(base) + k + 1 == int'(len_a_q)) fin_h = h[k];
    end

    assign score = score_q;

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !lane_en[0]);
    assert_score_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(finish)) |-> $stable(score));
endmodule

// File: tb/test_wavefront_score.sv
`timescale 1ns/1ps
module test_wavefront_score;
    localparam int LANES = 4, MAX_A = 16, MAX_B = 16;

    logic clk = 0, rst_n = 0;
    logic tab_we = 0, seq_we = 0, seq_is_b = 0, start = 0;
    logic [9:0] tab_addr = 0;
    logic [7:0] tab_data = 0, gap = 0;
    logic [3:0] seq_addr = 0;
    logic [4:0] seq_sym = 0, len_a = 1, len_b = 1;
    logic busy, done;
    logic [17:0] score;

    always #2 clk = ~clk;

    wavefront_score #(.LANES(LANES), .MAX_A(MAX_A), .MAX_B(MAX_B)) i_wavefront_score (
        .clk, .rst_n, .tab_we, .tab_addr, .tab_data, .seq_we, .seq_is_b,
        .seq_addr, .seq_sym, .len_a, .len_b, .gap, .start, .busy, .done, .score
    );

    int total = 0, bad = 0, cyc = 0;
    int tab_m [32][32];
    int sa [MAX_A], sb [MAX_B];
    int exp_q [$];
    string tag_q [$];

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_score(int la, int lb, int g);
        int hm [MAX_A+1][MAX_B+1];
        for (int i = 0; i <= la; i++) hm[i][0] = i * g;
        for (int j = 0; j <= lb; j++) hm[0][j] = j * g;
        for (int i = 1; i <= la; i++)
            for (int j = 1; j <= lb; j++) begin
                int m;
                m = hm[i-1][j-1] + tab_m[sa[i-1]][sb[j-1]];
                if (hm[i-1][j] + g > m) m = hm[i-1][j] + g;
                if (hm[i][j-1] + g > m) m = hm[i][j-1] + g;
                hm[i][j] = m;
            end
        return hm[la][lb];
    endfunction

    task automatic load_table(bit ident);
        for (int a = 0; a < 32; a++)
            for (int b = 0; b < 32; b++) begin
                int v;
                v = ident ? ((a == b) ? 5 : -2) : (int'($urandom_range(0, 40)) - 20);
                tab_m[a][b] = v;
                @(negedge clk);
                tab_we = 1; tab_addr = 10'({a[4:0], b[4:0]}); tab_data = 8'(v);
            end
        @(negedge clk); tab_we = 0;
    endtask

    task automatic load_seqs();
        for (int i = 0; i < 16; i++) begin
            sa[i] = $urandom_range(0, 23);
            sb[i] = $urandom_range(0, 23);
            @(negedge clk); seq_we = 1; seq_is_b = 0; seq_addr = 4'(i); seq_sym = 5'(sa[i]);
            @(negedge clk); seq_is_b = 1; seq_sym = 5'(sb[i]);
        end
        @(negedge clk); seq_we = 0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!(done && !busy) && n < 3000) begin @(negedge clk); n++; end
        check(n < 3000, "R7 run ends", n, 0);
    endtask

    // driver: starts a run and pushes the expected score to the scoreboard
    task automatic run(int la, int lb, int g, string tag, int disturb);
        @(negedge clk);
        len_a = 5'(la); len_b = 5'(lb); gap = 8'(g); start = 1;
        exp_q.push_back(ref_score(la, lb, g)); tag_q.push_back(tag);
        @(negedge clk); start = 0;
        check(busy && !done, "R7 busy set, done cleared after start", {busy, done}, 2);
        if (disturb == 1) begin // R5: writes while busy
            tab_we = 1; seq_we = 1;
            for (int i = 0; i < 6; i++) begin
                tab_addr = 10'({sa[i][4:0], sb[i][4:0]}); tab_data = 8'(99);
                seq_is_b = i[0]; seq_addr = 4'(i); seq_sym = 5'(23 - sa[i]);
                @(negedge clk);
            end
            tab_we = 0; seq_we = 0;
        end else if (disturb == 2) begin // R6: start while busy
            len_a = 1; len_b = 1; start = 1;
            @(negedge clk); start = 0;
        end else if (disturb == 3) begin // R8: inputs change mid run
            gap = 8'(-9); len_a = 2; len_b = 3;
            @(negedge clk);
        end
        wait_done();
    endtask

    // monitor: pops the scoreboard when done rises
    logic done_d = 0;
    always @(negedge clk) begin
        if (rst_n && done && !done_d) begin
            if (exp_q.size() == 0) check(0, "R2 unexpected done", 0, 0);
            else begin
                int e; string t;
                e = exp_q.pop_front(); t = tag_q.pop_front();
                check($signed(score) == e, t, $signed(score), e);
            end
        end
        done_d <= done;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && score == 0, "R1 reset state", {busy, done}, 0);
        rst_n = 1;
        load_table(0);
        load_seqs();
        run(1, 1, -3, "R4 min lengths", 0);
        run(4, 4, -3, "R2 one full strip", 0);
        run(5, 7, -4, "R3 strip remainder", 0);
        run(8, 3, -2, "R3 two full strips", 0);
        run(16, 16, -5, "R4 max lengths", 0);
        run(1, 16, -1, "R4 single row", 0);
        run(16, 1, -6, "R4 single column", 0);
        for (int r = 0; r < 6; r++)
            run($urandom_range(1, 16), $urandom_range(1, 16), -int'($urandom_range(0, 8)),
                "R2 random", 0);
        // R7: score and done hold while idle
        begin
            logic [17:0] s0;
            s0 = score;
            repeat (10) @(negedge clk);
            check(done && !busy && score == s0, "R7 hold", score, s0);
        end
        run(9, 11, -3, "R5 writes during run", 1);
        run(9, 11, -3, "R5 contents unchanged", 0);
        run(13, 6, -2, "R6 start ignored", 2);
        run(10, 12, -1, "R8 latched inputs", 3);
        load_table(1);
        run(7, 9, 0, "R2 zero gap", 0);
        run(12, 5, 3, "R2 positive gap", 0);
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule